// File: doc/BRIEF.md
# Deglitched Fault Flag Generator

This block produces the fault indication for a protected power switch. It watches two condition flags, one for current limiting and one for overtemperature, and drives a single open-drain-style output. A 1 on that output means the pin is pulled low to signal a fault. A 0 means the pin is released to high impedance. The block does not contain the analog pin driver or the detection circuits.

A current-limit condition must hold without a break for a programmable dwell before the flag is raised. The flag is released only after both conditions have stayed quiet for the same dwell. Neither timer accumulates: any break restarts it from zero. Overtemperature skips the entry dwell and raises the flag at once, but release after overtemperature still waits for the dwell. When the switch is disabled or held in undervoltage lockout, the flag is released immediately and both timers are cleared.

All four inputs are asynchronous and pass through a synchronizer. Every pin is a plain level signal, so the block has no valid/ready interface and no back-pressure.

Top module: `fault_flag_gen`

## Requirements
- R1: After reset, and with all inputs low, `flt_pull_o` is 0.
- R2: With `en_i`=1, `uvlo_i`=0 and `otemp_i`=0, if `ilim_i` rises and stays high, `flt_pull_o` is still 0 after DEGLITCH_CYCLES+1 clock edges and becomes 1 on edge DEGLITCH_CYCLES+2.
- R3: A current-limit episode that lasts fewer than DEGLITCH_CYCLES cycles never raises the flag. Several such episodes separated by low cycles also never raise it.
- R4: With the flag at 1, once `ilim_i` and `otemp_i` are both low and stay low, the flag is still 1 after DEGLITCH_CYCLES+1 edges and becomes 0 on edge DEGLITCH_CYCLES+2.
- R5: During release, a single cycle in which the condition returns restarts the release dwell from zero.
- R6: While the switch is active, a rise of `otemp_i` sets the flag on the third clock edge, with no entry dwell. This also holds while `ilim_i` is already high.
- R7: Lowering `en_i` clears a set flag on the third clock edge. It also zeroes the timers, so after `en_i` returns the full entry dwell (R2 latency, counted from the rise of `en_i`) is needed again.
- R8: Raising `uvlo_i` (1 = in lockout) clears a set flag on the third clock edge.
- R9: While `en_i`=0 or `uvlo_i`=1, the conditions are ignored and `flt_pull_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ilim_i | input | 1 | Current limiting is active (asynchronous) |
| otemp_i | input | 1 | Overtemperature shutdown is active (asynchronous) |
| en_i | input | 1 | Switch enabled, active high (asynchronous) |
| uvlo_i | input | 1 | Undervoltage lockout is active, active high (asynchronous) |
| flt_pull_o | output | 1 | 1 = pull the fault pin low, 0 = high impedance |

## Verification
Each input takes two edges to cross the synchronizer. The state register sees it on the third edge, so the fast paths (overtemperature, disable, lockout) are due on edge 3. Both the entry and release dwells are due on edge DEGLITCH_CYCLES+2 after the input change. The bench drives inputs on falling edges and samples on falling edges. Every timed check is made in pairs: one sample at the edge before the due edge confirms no change yet, and one sample at the due edge confirms the change.

// File: rtl/fault_flag_pkg.sv
package fault_flag_pkg;
  typedef enum logic {
    FLAG_CLEAR = 1'b0,
    FLAG_SET   = 1'b1
  } flag_state_e;
endpackage

// File: rtl/ff_sync.sv
module ff_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[b] <= '0;
      else         chain[b] <= {chain[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/ff_dwell_timer.sv
module ff_dwell_timer #(
  parameter int LIMIT = 8,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  output logic          done_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LastVal = CW'(LIMIT - 1);

  logic [CW-1:0] count_q;

  assign done_o  = run_i && !clr_i && (count_q == LastVal);
  assign count_o = count_q;

  // Non-integrating: any cycle without run drops the count to zero.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     count_q <= '0;
    else if (clr_i || !run_i || done_o) count_q <= '0;
    else                             count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/ff_flag_fsm.sv
module ff_flag_fsm
  import fault_flag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ilim_i,
  input  logic otemp_i,
  input  logic done_i,
  output logic run_o,
  output logic clr_o,
  output logic flag_o
);
  flag_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    run_o   = 1'b0;
    clr_o   = 1'b0;
    if (!active_i) begin
      state_d = FLAG_CLEAR;
      clr_o   = 1'b1;
    end else begin
      unique case (state_q)
        FLAG_CLEAR: begin
          if (otemp_i) begin
            state_d = FLAG_SET;
            clr_o   = 1'b1;
          end else begin
            run_o = ilim_i;
            if (done_i) state_d = FLAG_SET;
          end
        end
        FLAG_SET: begin
          run_o = !(ilim_i || otemp_i);
          if (done_i) state_d = FLAG_CLEAR;
        end
        default: state_d = FLAG_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FLAG_CLEAR;
    else         state_q <= state_d;
  end

  assign flag_o = (state_q == FLAG_SET);
endmodule

// File: rtl/fault_flag_gen.sv
module fault_flag_gen #(
  parameter int DEGLITCH_CYCLES = 900000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ilim_i,
  input  logic otemp_i,
  input  logic en_i,
  input  logic uvlo_i,
  output logic flt_pull_o
);
  localparam int CNT_W = $clog2(DEGLITCH_CYCLES + 1);

  logic [3:0]       raw_in, sync_out;
  logic             ilim_s, otemp_s, en_s, uvlo_s, active_s;
  logic             run, clr, done;
  logic [CNT_W-1:0] dwell_cnt;

  assign raw_in = {uvlo_i, en_i, otemp_i, ilim_i};

  ff_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(sync_out)
  );

  assign {uvlo_s, en_s, otemp_s, ilim_s} = sync_out;
  assign active_s = en_s && !uvlo_s;

  ff_dwell_timer #(.LIMIT(DEGLITCH_CYCLES), .CW(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .run_i(run),
    .done_o(done), .count_o(dwell_cnt)
  );

  ff_flag_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_s), .ilim_i(ilim_s),
    .otemp_i(otemp_s), .done_i(done), .run_o(run), .clr_o(clr),
    .flag_o(flt_pull_o)
  );
endmodule

// File: rtl/fault_flag_chk.sv
module fault_flag_chk #(
  parameter int DG = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ilim_s,
  input logic          otemp_s,
  input logic          en_s,
  input logic          uvlo_s,
  input logic          flt,
  input logic [CW-1:0] cnt
);
  // R7, R8, R9: an inactive switch never shows the flag on the next cycle
  p_inactive_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s || uvlo_s) |=> !flt);

  // R6: overtemperature on an active switch sets the flag one cycle later
  p_otemp_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !uvlo_s && otemp_s) |=> flt);

  // R2: the flag only rises when a condition was present
  p_rise_needs_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt) |-> $past(ilim_s || otemp_s));

  // R4: release on an active switch only after a quiet cycle
  p_fall_needs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flt) && $past(en_s && !uvlo_s)) |-> $past(!ilim_s && !otemp_s));

  // R3: the dwell counter never reaches the limit
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DG));
endmodule

bind fault_flag_gen fault_flag_chk #(.DG(DEGLITCH_CYCLES), .CW(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .ilim_s(ilim_s), .otemp_s(otemp_s),
  .en_s(en_s), .uvlo_s(uvlo_s), .flt(flt_pull_o), .cnt(dwell_cnt)
);

// File: tb/fault_flag_gen_tb_top.sv
module fault_flag_gen_tb_top;
  localparam int DG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ilim = 1'b0, otemp = 1'b0, en = 1'b0, uvlo = 1'b0;
  logic flt;
  int   n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  fault_flag_gen #(.DEGLITCH_CYCLES(DG), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ilim_i(ilim), .otemp_i(otemp),
    .en_i(en), .uvlo_i(uvlo), .flt_pull_o(flt)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_run++;
    if (flt !== exp) begin
      n_fail++;
      $display("FAIL %s: flt_pull_o=%b expected %b at %0t", req, flt, exp, $time);
    end
  endtask

  task automatic quiesce();
    ilim = 0; otemp = 0; uvlo = 0; en = 0;
    step(4);
    en = 1;
    step(4);
  endtask

  task automatic enter_fault();
    ilim = 1;
    step(DG + 2);
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0);
    quiesce();
    check("R1 idle", 1'b0);
  endtask

  task automatic t_entry();
    quiesce();
    ilim = 1;
    step(DG + 1); check("R2 before dwell", 1'b0);
    step(1);      check("R2 at dwell", 1'b1);
  endtask

  task automatic t_short();
    quiesce();
    for (int k = 0; k < 3; k++) begin
      ilim = 1; step(DG - 1);
      ilim = 0; step(2);
    end
    step(DG); check("R3 short episodes", 1'b0);
  endtask

  task automatic t_exit();
    quiesce(); enter_fault();
    ilim = 0;
    step(DG + 1); check("R4 before release", 1'b1);
    step(1);      check("R4 at release", 1'b0);
  endtask

  task automatic t_exit_restart();
    quiesce(); enter_fault();
    ilim = 0; step(DG - 1);
    ilim = 1; step(1);
    ilim = 0;
    step(DG + 1); check("R5 restarted dwell", 1'b1);
    step(1);      check("R5 release", 1'b0);
  endtask

  task automatic t_otemp();
    quiesce();
    ilim = 1; step(3);
    otemp = 1;
    step(2); check("R6 before fast", 1'b0);
    step(1); check("R6 fast set", 1'b1);
    ilim = 0; otemp = 0;
    step(DG + 1); check("R6 release dwelled", 1'b1);
    step(1);      check("R6 released", 1'b0);
  endtask

  task automatic t_disable();
    quiesce(); enter_fault();
    en = 0;
    step(2); check("R7 before clear", 1'b1);
    step(1); check("R7 cleared", 1'b0);
    en = 1;
    step(DG + 1); check("R7 timers restarted", 1'b0);
    step(1);      check("R7 re-entry", 1'b1);
  endtask

  task automatic t_uvlo();
    quiesce(); enter_fault();
    uvlo = 1;
    step(2); check("R8 before clear", 1'b1);
    step(1); check("R8 cleared", 1'b0);
  endtask

  task automatic t_ignored();
    quiesce();
    en = 0; ilim = 1; otemp = 1;
    step(DG + 6); check("R9 disabled ignores", 1'b0);
    en = 1; uvlo = 1;
    step(DG + 6); check("R9 lockout ignores", 1'b0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_entry();
    t_short();
    t_exit();
    t_exit_restart();
    t_otemp();
    t_disable();
    t_uvlo();
    t_ignored();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule